// File: doc/BRIEF.md
# Manual Serial Command Sequencer

This block gives a host direct, primitive-level control of the serial link to a power-management device. It is used to reset the device's serial slave before automatic operation. The host writes 16-bit command words. Each word asks for one primitive: release chip select, assert chip select, or clock one byte out on the data line. The words are decoded on entry and held in a small queue. A single engine replays them in order onto chip select, the serial clock and the data line.

Manual control holds the link only while three conditions are all true: the manual-enable input is 1, the mux-select input is 1, and the automatic access channel is disabled. At any other time the link pins are a registered copy of the automatic channel, the queue is emptied and the engine is held at rest. The sync-idle output tells the host when every queued primitive has finished. The host then drops manual-enable and mux-select to hand the link back.

Top module: `serial_manual_seq`

## Requirements
- R1: In reset and just after it, with the automatic channel idle, chip select is high, the serial clock and data line are low, sync-idle is 1 and the overflow flag is 0.
- R2: Commands are taken only while manual-enable is 1, mux-select is 1 and the automatic-channel enable is 0. A command written at any other time has no effect on the link.
- R3: The opcode sits in command bits 11:8. Opcode 0x1 drives chip select low. Opcode 0x0 drives it high.
- R4: Opcode 0x8 emits 8 serial clock pulses, most significant bit first. If bit 13 is 1, the line carries bits 7:0 of the word. If bit 13 is 0, the line is held low.
- R5: During a shift the serial clock period is CLK_DIV system cycles with a high time of CLK_DIV/2 cycles. The clock rests low between primitives.
- R6: Opcodes other than 0x0, 0x1 and 0x8 have no effect on the link. So has any word with bit 15, 14 or 12 set.
- R7: The queue holds FIFO_DEPTH commands and runs them in write order. A write while it is full is dropped and sets a sticky overflow flag, cleared only by reset.
- R8: Sync-idle is 0 from the cycle after a command is accepted until the queue is empty and the last primitive has finished, and then returns to 1.
- R9: While manual control is not in effect, the link outputs copy the automatic channel inputs one cycle later. Leaving manual control discards queued and running primitives and returns chip select high for the next manual session.
- R10: The slave-reset order works as expected: chip select low, one shift, chip select high, then four shifts. The first byte is clocked with chip select low and the next four with it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| man_en_i | input | 1 | Manual-enable setting |
| mux_sel_i | input | 1 | Mux-select setting handing the link to the manual path |
| auto_en_i | input | 1 | Automatic access channel enabled |
| cmd_valid_i | input | 1 | Command write strobe, one cycle per command |
| cmd_word_i | input | 16 | Command word |
| auto_cs_n_i | input | 1 | Chip select from the automatic channel |
| auto_sck_i | input | 1 | Serial clock from the automatic channel |
| auto_mosi_i | input | 1 | Data line from the automatic channel |
| ser_cs_n_o | output | 1 | Link chip select, active low |
| ser_sck_o | output | 1 | Link serial clock |
| ser_mosi_o | output | 1 | Link data output |
| sync_idle_o | output | 1 | All queued primitives have finished |
| overflow_o | output | 1 | Sticky flag: a command was dropped on a full queue |

## Verification
The hardest condition to reach from the ports is a full queue. The engine pops each command the cycle after it lands, so commands written at a relaxed pace never fill it. The bench therefore writes six byte-shift commands on consecutive cycles. The first shift keeps the engine busy for 8·CLK_DIV cycles while the next four fill every slot, and the sixth write meets a full queue. The clocked-out bit stream must then hold exactly the first five bytes in order. A second hard condition is dropping manual control in the middle of a byte. The bench cuts the handover part-way through a shift, re-enters manual mode and confirms that no further clock pulses appear and that chip select starts high.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam int CMD_W   = 16;
  localparam int OP_LSB  = 8;
  localparam int OP_W    = 4;
  localparam int WR_BIT  = 13;
  localparam int DATA_W  = 8;

  localparam logic [OP_W-1:0] OPC_CS_HIGH = 4'h0;
  localparam logic [OP_W-1:0] OPC_CS_LOW  = 4'h1;
  localparam logic [OP_W-1:0] OPC_SHIFT   = 4'h8;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_CS_HIGH,
    ACT_CS_LOW,
    ACT_SHIFT
  } act_e;

  typedef struct packed {
    act_e              act;
    logic              wr;
    logic [DATA_W-1:0] data;
  } prim_t;

  localparam int PRIM_W = $bits(prim_t);

  function automatic prim_t decode_cmd(input logic [CMD_W-1:0] w);
    prim_t p;
    logic  rsvd;
    rsvd   = w[15] | w[14] | w[12];
    p.wr   = w[WR_BIT];
    p.data = w[DATA_W-1:0];
    p.act  = ACT_NONE;
    if (!rsvd) begin
      case (w[OP_LSB+OP_W-1:OP_LSB])
        OPC_CS_HIGH: p.act = ACT_CS_HIGH;
        OPC_CS_LOW:  p.act = ACT_CS_LOW;
        OPC_SHIFT:   p.act = ACT_SHIFT;
        default:     p.act = ACT_NONE;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/mseq_fifo.sv
module mseq_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  logic do_wr, do_rd;
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign rd_data = mem[rd_ptr];

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)) else $error("queue count past depth"); // R7

endmodule

// File: rtl/mseq_engine.sv
module mseq_engine
  import mseq_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  avail,
  input  prim_t prim,
  output logic  pop,
  output logic  idle,
  output logic  cs_n,
  output logic  sck,
  output logic  mosi
);

  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DW-1:0] HALF_END = DW'(HALF - 1);

  typedef enum logic {ST_IDLE, ST_SHIFT} st_e;

  st_e               state;
  logic [DW-1:0]     div_q;
  logic [2:0]        bit_q;
  logic [DATA_W-1:0] shreg;
  logic              wr_q;
  logic              cs_q, sck_q, mosi_q;

  assign pop  = en && avail && (state == ST_IDLE);
  assign idle = (state == ST_IDLE);
  assign cs_n = cs_q;
  assign sck  = sck_q;
  assign mosi = mosi_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state  <= ST_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      shreg  <= '0;
      wr_q   <= 1'b0;
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (pop) begin
            case (prim.act)
              ACT_CS_HIGH: cs_q <= 1'b1;
              ACT_CS_LOW:  cs_q <= 1'b0;
              ACT_SHIFT: begin
                state  <= ST_SHIFT;
                shreg  <= prim.data;
                wr_q   <= prim.wr;
                mosi_q <= prim.wr & prim.data[DATA_W-1];
                div_q  <= '0;
                bit_q  <= '0;
              end
              default: ;
            endcase
          end
        end
        ST_SHIFT: begin
          if (div_q == HALF_END) begin
            div_q <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1;
            end else begin
              sck_q <= 1'b0;
              if (bit_q == 3'd7) begin
                state  <= ST_IDLE;
                mosi_q <= 1'b0;
              end else begin
                bit_q  <= bit_q + 1'b1;
                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                mosi_q <= wr_q & shreg[DATA_W-2];
              end
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sck_q) else $error("clock high at rest"); // R5

endmodule

// File: rtl/mseq_link_mux.sv
module mseq_link_mux (
  input  logic clk,
  input  logic rst,
  input  logic manual,
  input  logic man_cs_n,
  input  logic man_sck,
  input  logic man_mosi,
  input  logic auto_cs_n,
  input  logic auto_sck,
  input  logic auto_mosi,
  output logic cs_n_q,
  output logic sck_q,
  output logic mosi_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q <= 1'b1;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
    end else if (manual) begin
      cs_n_q <= man_cs_n;
      sck_q  <= man_sck;
      mosi_q <= man_mosi;
    end else begin
      cs_n_q <= auto_cs_n;
      sck_q  <= auto_sck;
      mosi_q <= auto_mosi;
    end
  end

  AST_AUTO_PASS: assert property (@(posedge clk) disable iff (rst)
    !manual |=> (cs_n_q == $past(auto_cs_n)) && (sck_q == $past(auto_sck)))
    else $error("automatic channel not passed through"); // R9

endmodule

// File: rtl/serial_manual_seq.sv
module serial_manual_seq
  import mseq_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int CLK_DIV    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        man_en_i,
  input  logic        mux_sel_i,
  input  logic        auto_en_i,
  input  logic        cmd_valid_i,
  input  logic [15:0] cmd_word_i,
  input  logic        auto_cs_n_i,
  input  logic        auto_sck_i,
  input  logic        auto_mosi_i,
  output logic        ser_cs_n_o,
  output logic        ser_sck_o,
  output logic        ser_mosi_o,
  output logic        sync_idle_o,
  output logic        overflow_o
);

  logic  manual;
  logic  push, drop;
  prim_t in_prim, head;
  logic  q_empty, q_full, pop, eng_idle;
  logic  eng_cs_n, eng_sck, eng_mosi;

  assign manual  = man_en_i && mux_sel_i && !auto_en_i;
  assign in_prim = decode_cmd(cmd_word_i);
  assign push    = cmd_valid_i && manual && !q_full;
  assign drop    = cmd_valid_i && manual && q_full;

  mseq_fifo #(
    .WIDTH (PRIM_W),
    .DEPTH (FIFO_DEPTH)
  ) i_queue (
    .clk     (clk),
    .rst     (rst),
    .flush   (!manual),
    .wr_en   (push),
    .wr_data (in_prim),
    .rd_en   (pop),
    .rd_data (head),
    .empty   (q_empty),
    .full    (q_full)
  );

  mseq_engine #(
    .CLK_DIV (CLK_DIV)
  ) i_engine (
    .clk   (clk),
    .rst   (rst),
    .en    (manual),
    .avail (!q_empty),
    .prim  (head),
    .pop   (pop),
    .idle  (eng_idle),
    .cs_n  (eng_cs_n),
    .sck   (eng_sck),
    .mosi  (eng_mosi)
  );

  mseq_link_mux i_mux (
    .clk       (clk),
    .rst       (rst),
    .manual    (manual),
    .man_cs_n  (eng_cs_n),
    .man_sck   (eng_sck),
    .man_mosi  (eng_mosi),
    .auto_cs_n (auto_cs_n_i),
    .auto_sck  (auto_sck_i),
    .auto_mosi (auto_mosi_i),
    .cs_n_q    (ser_cs_n_o),
    .sck_q     (ser_sck_o),
    .mosi_q    (ser_mosi_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_idle_o <= 1'b1;
      overflow_o  <= 1'b0;
    end else begin
      sync_idle_o <= q_empty && eng_idle && !push;
      if (drop) overflow_o <= 1'b1;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o) else $error("overflow flag lost"); // R7

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    sync_idle_o |-> q_empty) else $error("idle with queued work"); // R8

  AST_PUSH_BUSY: assert property (@(posedge clk) disable iff (rst)
    push |=> !sync_idle_o) else $error("idle right after accept"); // R8

endmodule

// File: tb/test_serial_manual_seq.sv
module test_serial_manual_seq;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int DEPTH      = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        man_en = 1'b0, mux_sel = 1'b0, auto_en = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        auto_cs_n = 1'b1, auto_sck = 1'b0, auto_mosi = 1'b0;
  logic        ser_cs_n, ser_sck, ser_mosi, sync_idle, overflow;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_manual_seq #(.FIFO_DEPTH(DEPTH), .CLK_DIV(DIV)) i_serial_manual_seq (
    .clk(clk), .rst(rst), .man_en_i(man_en), .mux_sel_i(mux_sel),
    .auto_en_i(auto_en), .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .auto_cs_n_i(auto_cs_n), .auto_sck_i(auto_sck), .auto_mosi_i(auto_mosi),
    .ser_cs_n_o(ser_cs_n), .ser_sck_o(ser_sck), .ser_mosi_o(ser_mosi),
    .sync_idle_o(sync_idle), .overflow_o(overflow)
  );

  // link monitor
  logic [63:0] cap = '0;
  int  n_rise = 0, rise_lo = 0, rise_hi = 0;
  time t_rise = 0, per = 0, hi_time = 0;
  always @(posedge ser_sck) begin
    cap = {cap[62:0], ser_mosi};
    n_rise++;
    if (ser_cs_n) rise_hi++; else rise_lo++;
    per = $time - t_rise;
    t_rise = $time;
  end
  always @(negedge ser_sck) hi_time = $time - t_rise;

  // {cmd[15:0], cs_n, nbits[3:0], byte[7:0]}
  localparam logic [28:0] VEC [11] = '{
    {16'h0100, 1'b0, 4'd0, 8'h00},   // R3 chip select low
    {16'h28A5, 1'b0, 4'd8, 8'hA5},   // R4 write shift
    {16'h083C, 1'b0, 4'd8, 8'h00},   // R4 shift, line held low
    {16'h0000, 1'b1, 4'd0, 8'h00},   // R3 chip select high
    {16'h0512, 1'b1, 4'd0, 8'h00},   // R6 unknown opcode
    {16'h0100, 1'b0, 4'd0, 8'h00},   // R3
    {16'h0F77, 1'b0, 4'd0, 8'h00},   // R6 unknown opcode
    {16'h4000, 1'b0, 4'd0, 8'h00},   // R6 reserved bit set
    {16'h2801, 1'b0, 4'd8, 8'h01},   // R4
    {16'h2880, 1'b0, 4'd8, 8'h80},   // R4
    {16'h0000, 1'b1, 4'd0, 8'h00}    // R3
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && !sync_idle; k++) @(negedge clk);
  endtask

  task automatic set_manual(input logic on);
    man_en  = on;
    mux_sel = on;
  endtask

  initial begin
    int n0, lo0, hi0;
    logic [28:0] v;

    // R1 reset state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 cs_n in reset", ser_cs_n, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cs_n", ser_cs_n, 1);
    chk("R1 sck", ser_sck, 0);
    chk("R1 mosi", ser_mosi, 0);
    chk("R1 sync_idle", sync_idle, 1);
    chk("R1 overflow", overflow, 0);

    // R9 pass-through of automatic channel
    auto_cs_n = 1'b0; auto_sck = 1'b1; auto_mosi = 1'b1;
    @(negedge clk);
    chk("R9 cs follows", ser_cs_n, 0);
    chk("R9 sck follows", ser_sck, 1);
    chk("R9 mosi follows", ser_mosi, 1);
    auto_cs_n = 1'b1; auto_sck = 1'b0; auto_mosi = 1'b0;
    repeat (2) @(negedge clk);

    // R2 gating: auto channel enabled blocks manual mode
    n0 = n_rise;
    set_manual(1'b1); auto_en = 1'b1;
    push(16'h0100);
    push(16'h28FF);
    repeat (60) @(negedge clk);
    chk("R2 auto_en blocks cs", ser_cs_n, 1);
    chk("R2 auto_en blocks shift", n_rise, n0);
    auto_en = 1'b0; mux_sel = 1'b0;
    push(16'h0100);
    repeat (4) @(negedge clk);
    chk("R2 mux_sel low blocks", ser_cs_n, 1);
    mux_sel = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 no stale command", ser_cs_n, 1);
    chk("R2 sync_idle", sync_idle, 1);

    // table walk
    for (int i = 0; i < 11; i++) begin
      v  = VEC[i];
      n0 = n_rise;
      push(v[28:13]);
      chk($sformatf("R8 busy after push v%0d", i), sync_idle, 0);
      wait_idle();
      @(negedge clk);
      chk($sformatf("R8 idle v%0d", i), sync_idle, 1);
      chk($sformatf("R3 cs_n v%0d", i), ser_cs_n, v[12]);
      chk($sformatf("R4 clock count v%0d", i), n_rise - n0, v[11:8]);
      if (v[11:8] != 0) chk($sformatf("R4 byte v%0d", i), cap[7:0], v[7:0]);
    end

    // R5 clock timing from the last shift
    chk("R5 period", per, DIV*CLK_PERIOD);
    chk("R5 high time", hi_time, (DIV/2)*CLK_PERIOD);
    chk("R5 rests low", ser_sck, 0);

    // R9 leave manual mode in the middle of a shift
    push(16'h0100);
    wait_idle();
    push(16'h28FF);
    repeat (6) @(negedge clk);
    set_manual(1'b0);
    repeat (2) @(negedge clk);
    chk("R9 cs follows after handover", ser_cs_n, 1);
    chk("R9 sck follows after handover", ser_sck, 0);
    n0 = n_rise;
    set_manual(1'b1);
    repeat (60) @(negedge clk);
    chk("R9 shift discarded", n_rise, n0);
    chk("R9 cs high on re-entry", ser_cs_n, 1);
    chk("R9 idle on re-entry", sync_idle, 1);

    // R10 slave-reset order
    do_reset();
    set_manual(1'b1);
    n0 = n_rise; lo0 = rise_lo; hi0 = rise_hi;
    push(16'h0100);
    push(16'h2800);
    push(16'h0000);
    wait_idle();
    for (int k = 0; k < 4; k++) push(16'h2800);
    wait_idle();
    @(negedge clk);
    chk("R10 total clocks", n_rise - n0, 40);
    chk("R10 clocks with cs low", rise_lo - lo0, 8);
    chk("R10 clocks with cs high", rise_hi - hi0, 32);
    chk("R10 cs_n end", ser_cs_n, 1);
    chk("R10 no overflow", overflow, 0);
    set_manual(1'b0);

    // R7 fill queue behind a running shift
    do_reset();
    set_manual(1'b1);
    n0 = n_rise;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_word  = 16'h2800 | 16'(8'h11 * (k + 1));
    end
    @(negedge clk);
    chk("R7 no overflow before full write", overflow, 0);
    cmd_word = 16'h28EE;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7 overflow set", overflow, 1);
    wait_idle();
    @(negedge clk);
    chk("R7 clocks for five bytes", n_rise - n0, 40);
    chk("R7 order", cap[39:0], 40'h1122334455);
    chk("R7 overflow sticky", overflow, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule